// File: doc/BRIEF.md
# Address Relocation and Protection Unit

This block turns an 18-bit processor address into the address driven onto the memory bus. The address is read as an 8-bit page field (bits 17..10) over a 10-bit offset (bits 9..0). When the access runs in user mode, the page field is offset by a relocation base. In every other case the page field passes through unchanged. The unrelocated page is also compared against a protection limit, and addresses in the lowest sixteen words can be steered to a small fast register memory.

A controller raises `loadStb` at the start of a memory cycle. On that edge the unit captures the relocated bus address and three flags: address-OK, relocation-inhibit and fast-memory select. All four outputs then hold steady until the next strobe. The unit only reports the illegal-address condition. Raising the fault is the caller's job.

Top module: `relocUnit`

## Requirements
- R1: After reset, every output is zero: `busAddr`, `fastSel`, `addrOk` and `relInhibit`.
- R2: `busAddr[9:0]` equals `procAddr[9:0]` as captured at the last load.
- R3: When relocation is not inhibited, `busAddr[17:10]` equals (`procAddr[17:10]` + `relocBase`) mod 256. The carry out of the sum is dropped.
- R4: When relocation is inhibited, `busAddr[17:10]` equals `procAddr[17:10]`.
- R5: `relInhibit` is 1 when `userMode` is 0, or `intSync` is 1, or `illegalOp` is 1, or `procAddr[17:4]` is zero (address below 16).
- R6: `addrOk` is 1 exactly when the unrelocated `procAddr[17:10]` is less than or equal to `protLimit`.
- R7: `fastSel` is 1 exactly when `procAddr[17:4]` is zero and `maintMode` is 0.
- R8: The outputs change only on a clock edge where `loadStb` is 1. Input changes while `loadStb` is 0 have no effect on them.
- R9: `illegalAddr` is 1 exactly when the registered `addrOk` is 0 and the registered `relInhibit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadStb | input | 1 | Capture strobe for a new address |
| procAddr | input | 18 | Processor address |
| relocBase | input | 8 | Relocation base added to the page field |
| protLimit | input | 8 | Highest page the user may reach |
| userMode | input | 1 | Processor is in user mode |
| intSync | input | 1 | Interrupt sync is active |
| illegalOp | input | 1 | Illegal-operation condition |
| maintMode | input | 1 | Maintenance/read-in mode, disables fast memory |
| busAddr | output | 18 | Registered bus address |
| fastSel | output | 1 | Registered fast-memory select |
| addrOk | output | 1 | Registered protection pass |
| relInhibit | output | 1 | Registered relocation-inhibit flag |
| illegalAddr | output | 1 | Illegal-address condition for the current access |

## Verification
The bench exercises address 15 against address 16. A design with a wrong low-address mask would relocate address 15 or fail to assert fast select for it. It drives a page equal to the protection limit and one page above it. An off-by-one comparator would flag the boundary page, or pass the page above it. It adds bases that wrap past 255; a design that kept the carry would corrupt bit 17 or grow the field. Each inhibit cause is also driven alone, so that dropping any single term from the inhibit logic leaves a relocated page where a passed-through page is expected. Random stimulus with the strobe held low then confirms that nothing leaks through between loads.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
  parameter int ADDR_W = 18;
  parameter int PAGE_W = 8;
  localparam int OFFS_W = ADDR_W - PAGE_W;
  parameter int FAST_W = 4;

  typedef struct packed {
    logic load;
  } ctlStrobe_t;

  typedef struct packed {
    logic inhibit;
    logic ok;
    logic fast;
  } flags_t;
endpackage

// File: rtl/relocCtrl.sv
module relocCtrl
  import reloc_pkg::*;
(
  input  logic              loadStb,
  input  logic [ADDR_W-1:0] procAddr,
  input  logic [PAGE_W-1:0] protLimit,
  input  logic              userMode,
  input  logic              intSync,
  input  logic              illegalOp,
  input  logic              maintMode,
  output ctlStrobe_t        strobe,
  output flags_t            flagsNext
);
  logic lowAddr;
  logic [PAGE_W-1:0] page;

  always_comb begin
    lowAddr = (procAddr[ADDR_W-1:FAST_W] == '0);
    page    = procAddr[ADDR_W-1:OFFS_W];
    flagsNext.inhibit = !userMode || intSync || lowAddr || illegalOp;
    flagsNext.ok      = (page <= protLimit);
    flagsNext.fast    = lowAddr && !maintMode;
    strobe.load       = loadStb;
  end
endmodule

// File: rtl/relocDatapath.sv
module relocDatapath
  import reloc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  flags_t            flagsNext,
  input  logic [ADDR_W-1:0] procAddr,
  input  logic [PAGE_W-1:0] relocBase,
  output logic [ADDR_W-1:0] busAddr,
  output flags_t            flagsQ
);
  logic [PAGE_W-1:0] pageIn;
  logic [PAGE_W-1:0] pageOut;

  always_comb begin
    pageIn  = procAddr[ADDR_W-1:OFFS_W];
    pageOut = flagsNext.inhibit ? pageIn : PAGE_W'(pageIn + relocBase);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAddr <= '0;
      flagsQ  <= '0;
    end else if (strobe.load) begin
      busAddr <= {pageOut, procAddr[OFFS_W-1:0]};
      flagsQ  <= flagsNext;
    end
  end
endmodule

// File: rtl/relocUnit.sv
module relocUnit
  import reloc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStb,
  input  logic [ADDR_W-1:0] procAddr,
  input  logic [PAGE_W-1:0] relocBase,
  input  logic [PAGE_W-1:0] protLimit,
  input  logic              userMode,
  input  logic              intSync,
  input  logic              illegalOp,
  input  logic              maintMode,
  output logic [ADDR_W-1:0] busAddr,
  output logic              fastSel,
  output logic              addrOk,
  output logic              relInhibit,
  output logic              illegalAddr
);
  ctlStrobe_t strobe;
  flags_t     flagsNext;
  flags_t     flagsQ;

  relocCtrl u_ctrl (
    .loadStb(loadStb), .procAddr(procAddr), .protLimit(protLimit),
    .userMode(userMode), .intSync(intSync), .illegalOp(illegalOp),
    .maintMode(maintMode), .strobe(strobe), .flagsNext(flagsNext)
  );

  relocDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .flagsNext(flagsNext),
    .procAddr(procAddr), .relocBase(relocBase),
    .busAddr(busAddr), .flagsQ(flagsQ)
  );

  assign fastSel     = flagsQ.fast;
  assign addrOk      = flagsQ.ok;
  assign relInhibit  = flagsQ.inhibit;
  assign illegalAddr = !flagsQ.ok && !flagsQ.inhibit;
endmodule

// File: rtl/relocUnit_chk.sv
module relocUnit_chk
  import reloc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              loadStb,
  input logic [ADDR_W-1:0] procAddr,
  input logic [PAGE_W-1:0] relocBase,
  input logic [PAGE_W-1:0] protLimit,
  input logic              userMode,
  input logic              intSync,
  input logic              illegalOp,
  input logic              maintMode,
  input logic [ADDR_W-1:0] busAddr,
  input logic              fastSel,
  input logic              addrOk,
  input logic              relInhibit,
  input logic              illegalAddr
);
  a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> busAddr[OFFS_W-1:0] == $past(procAddr[OFFS_W-1:0]));

  a_r3_reloc_add: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && userMode && !intSync && !illegalOp && procAddr[ADDR_W-1:FAST_W] != '0)
    |=> busAddr[ADDR_W-1:OFFS_W] ==
        PAGE_W'($past(procAddr[ADDR_W-1:OFFS_W]) + $past(relocBase)));

  a_r4_passthru: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && !userMode) |=> busAddr == $past(procAddr));

  a_r6_prot: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> addrOk == ($past(procAddr[ADDR_W-1:OFFS_W]) <= $past(protLimit)));

  a_r7_fast: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> fastSel == ($past(procAddr[ADDR_W-1:FAST_W]) == '0 && !$past(maintMode)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !loadStb |=> $stable(busAddr) && $stable(addrOk) && $stable(fastSel) && $stable(relInhibit));

  a_r9_fault: assert property (@(posedge clk) disable iff (!rstN)
    illegalAddr |-> !addrOk && !relInhibit);
endmodule

bind relocUnit relocUnit_chk u_chk (.*);

// File: tb/relocUnit_tb.sv
module relocUnit_tb;
  logic clk = 0, rstN = 0, loadStb = 0;
  logic [17:0] procAddr = 0;
  logic [7:0] relocBase = 0, protLimit = 0;
  logic userMode = 0, intSync = 0, illegalOp = 0, maintMode = 0;
  logic [17:0] busAddr;
  logic fastSel, addrOk, relInhibit, illegalAddr;
  int total = 0, bad = 0;
  logic [17:0] expAddr;
  logic expFast, expOk, expInh;

  always #5 clk = ~clk;

  relocUnit u_dut (.*);

  function automatic logic inhF(logic [17:0] a, logic u, logic s, logic il);
    return !u || s || il || (a[17:4] == 0);
  endfunction

  function automatic logic [17:0] addrF(logic [17:0] a, logic [7:0] b, logic inh);
    logic [7:0] p = inh ? a[17:10] : 8'(a[17:10] + b);
    return {p, a[9:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic apply(logic [17:0] a, logic [7:0] b, logic [7:0] l,
                       logic u, logic s, logic il, logic m);
    @(negedge clk);
    procAddr = a; relocBase = b; protLimit = l;
    userMode = u; intSync = s; illegalOp = il; maintMode = m;
    loadStb = 1;
    @(negedge clk);
    loadStb = 0;
    expInh  = inhF(a, u, s, il);
    expAddr = addrF(a, b, expInh);
    expOk   = a[17:10] <= l;
    expFast = (a[17:4] == 0) && !m;
    check("R2/R3/R4 busAddr", 32'(busAddr), 32'(expAddr));
    check("R5 relInhibit", 32'(relInhibit), 32'(expInh));
    check("R6 addrOk", 32'(addrOk), 32'(expOk));
    check("R7 fastSel", 32'(fastSel), 32'(expFast));
    check("R9 illegalAddr", 32'(illegalAddr), 32'(!expOk && !expInh));
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    #22;
    check("R1 busAddr", 32'(busAddr), 0);
    check("R1 flags", 32'({fastSel, addrOk, relInhibit}), 0);
    rstN = 1;
    apply(18'd15, 8'h10, 8'h00, 1, 0, 0, 0);
    apply(18'd16, 8'h10, 8'h00, 1, 0, 0, 0);
    apply(18'd15, 8'h10, 8'h00, 1, 0, 0, 1);
    apply({8'h20, 10'h3a5}, 8'h05, 8'h20, 1, 0, 0, 0);
    apply({8'h21, 10'h3a5}, 8'h05, 8'h20, 1, 0, 0, 0);
    apply({8'hf0, 10'h001}, 8'h20, 8'hff, 1, 0, 0, 0);
    apply({8'h40, 10'h001}, 8'h20, 8'h00, 0, 0, 0, 0);
    apply({8'h40, 10'h001}, 8'h20, 8'h00, 1, 1, 0, 0);
    apply({8'h40, 10'h001}, 8'h20, 8'h00, 1, 0, 1, 0);
    for (int i = 0; i < 300; i++) begin
      logic [17:0] a = 18'($urandom);
      if (i % 4 == 0) a[17:4] = 0;
      apply(a, 8'($urandom), 8'($urandom), 1'($urandom_range(0, 3) != 0),
            1'($urandom_range(0, 5) == 0), 1'($urandom_range(0, 5) == 0),
            1'($urandom));
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        procAddr = 18'($urandom); relocBase = 8'($urandom);
        protLimit = 8'($urandom); userMode = 1'($urandom);
        maintMode = 1'($urandom);
      end
      @(negedge clk);
      check("R8 hold addr", 32'(busAddr), 32'(expAddr));
      check("R8 hold flags", 32'({fastSel, addrOk, relInhibit}),
            32'({expFast, expOk, expInh}));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule